// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers one-cycle event pulses from peripherals and turns them into three interrupt request lines, each at its own priority level. Every pulse carries a 7-bit event code. The upper two bits of the code pick one of three 32-bit pending words. The lower five bits pick a bit inside that word. The addressed bit is latched until software clears it.

Three independent mask sets filter the pending words: set A, set B and set C. Each set holds one mask word per pending word. A request line is high whenever any pending bit lines up with a set bit of its mask set. Set A drives the highest-priority line, set B the middle one and set C the lowest.

A simple register port lets software do three things. It can read the pending words. It can clear pending bits by writing ones. It can read and write all nine mask words. Both the event path and the register port act on the same clock edge.

Top module: `evt_irq_agg`

## Requirements
- R1: While reset is asserted and after it is released, all three pending words and all nine mask words read as zero, and all three request outputs are low.
- R2: An event pulse with code c sets bit c[4:0] of pending word c[6:5] on the next clock edge and leaves every other pending bit unchanged.
- R3: An event whose code has c[6:5] equal to 3 sets no pending bit.
- R4: A write to pending word k (offsets 0 to 2) clears each bit that is one in the write data and keeps each bit that is zero in it.
- R5: A read of any register has no side effect: reading a pending word again returns the same value.
- R6: The request output irq_hi is high when any pending word ANDed with its mask-A word (offsets 4 to 6) is nonzero. irq_mid does the same with mask B (offsets 8 to 10), and irq_lo does the same with mask C (offsets 12 to 14).
- R7: The request outputs are level-sensitive and take effect right after the clock edge that changes their inputs. After a clearing write or a mask change, the affected output drops in the cycle that follows the write.
- R8: When an event and a clearing write hit the same pending bit in one cycle, the bit is left set.
- R9: Each mask word keeps the exact value last written to it and reads it back unchanged.
- R10: Offsets 3, 7, 11 and 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | One-cycle event pulse |
| evt_code | input | 7 | Event code: bits 6:5 pick the word, bits 4:0 pick the bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_hi | output | 1 | Request through mask set A |
| irq_mid | output | 1 | Request through mask set B |
| irq_lo | output | 1 | Request through mask set C |

## Verification
The bench builds the block with its default parameters: 32-bit words, three banks and a 2-bit bank field. With these values the fourth code bank and the fourth offset of every register group are left unused, so the reserved-code rule and the unused-offset rule can be driven directly. The bench runs a same-cycle clear and event on one word, and it sweeps all 32 bit positions of the top bank, so the edges of the code field are exercised.

// File: rtl/evt_irq_pkg.sv
// Shared constants and the register-group encoding for the event aggregator.
package evt_irq_pkg;

    // Number of request levels, one mask set per level.
    localparam int NUM_LEVELS = 3;

    // Width of the register-group field at the top of the word offset.
    localparam int GRP_W = 2;

    // Register group held in the upper offset bits.
    typedef enum logic [GRP_W-1:0] {
        GRP_PEND   = 2'd0,
        GRP_MASK_A = 2'd1,
        GRP_MASK_B = 2'd2,
        GRP_MASK_C = 2'd3
    } reg_grp_e;

endpackage

// File: rtl/evt_code_decode.sv
// Turns an event pulse and its code into one set vector per bank.
// Assumes: the code is {bank, bit}; a bank index of NUM_BANKS or more is
// reserved and produces no set.
module evt_code_decode #(
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 3,
    parameter int BANK_SEL_W = 2,
    parameter int BIT_W      = $clog2(WORD_W),
    parameter int CODE_W     = BANK_SEL_W + BIT_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 evt_valid,
    input  logic [CODE_W-1:0]                    evt_code,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]     set_vec
);

    logic [BANK_SEL_W-1:0] bank_idx;
    logic [BIT_W-1:0]      bit_idx;
    logic [WORD_W-1:0]     bit_onehot;

    // Split the code into its bank and bit fields.
    always_comb begin
        bank_idx   = evt_code[CODE_W-1:BIT_W];
        bit_idx    = evt_code[BIT_W-1:0];
        bit_onehot = WORD_W'(1) << bit_idx;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Route the one-hot bit to the bank the code names.
        always_comb begin
            set_vec[b] = (evt_valid && (int'(bank_idx) == b)) ? bit_onehot : '0;
        end
    end

    // R3: reserved bank codes never produce a set.
    a_r3_reserved_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (int'(evt_code[CODE_W-1:BIT_W]) >= NUM_BANKS)) |-> (set_vec == '0));

    // R2: a valid event sets exactly one bit across all banks.
    a_r2_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (int'(evt_code[CODE_W-1:BIT_W]) < NUM_BANKS)) |-> ($countones(set_vec) == 1));

endmodule

// File: rtl/pend_bank.sv
// One pending word: bits are set by events and cleared by write-one-to-clear.
// Assumes: set and clear vectors are valid for a single cycle; a set on the
// same bit as a clear keeps the bit set.
module pend_bank #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    output logic [WORD_W-1:0] pend
);

    // Apply clears first, then sets, so an event beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end

    // R4: a cleared bit with no competing event reads zero next cycle.
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    // R8: every bit hit by an event is set next cycle, clear or not.
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R2: a pending bit only rises where an event pointed.
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/mask_file.sv
// Storage for every mask word of every level, one write enable per word.
// Assumes: at most one write enable is active per cycle.
module mask_file #(
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 3,
    parameter int NUM_LEVELS = 3
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic [NUM_LEVELS-1:0][NUM_BANKS-1:0]                 wr_en,
    input  logic [WORD_W-1:0]                                    wr_data,
    output logic [NUM_LEVELS-1:0][NUM_BANKS-1:0][WORD_W-1:0]     mask
);

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Hold one mask word; load it on its own enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask[l][b] <= '0;
                end else if (wr_en[l][b]) begin
                    mask[l][b] <= wr_data;
                end
            end
        end
    end

    // R9: an unwritten mask word keeps its value.
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(mask));

endmodule

// File: rtl/level_combine.sv
// Reduces pending words against one mask set to a single request level.
// Assumes: pending and mask arrays are aligned bank for bank.
module level_combine #(
    parameter int WORD_W    = 32,
    parameter int NUM_BANKS = 3
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] pend,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] mask,
    output logic                             req
);

    // OR the masked pending bits over all banks.
    always_comb begin
        req = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            req = req | (|(pend[b] & mask[b]));
        end
    end

endmodule

// File: rtl/evt_irq_agg.sv
// Top: event decode, pending words, mask sets and per-level request lines,
// plus the register port that reads them and clears or loads them.
// Assumes: synchronous active-low reset; reads are combinational and free of
// side effects; offsets whose bank field is NUM_BANKS or more are unused.
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 3,
    parameter int BANK_SEL_W = 2,
    parameter int CODE_W     = BANK_SEL_W + $clog2(WORD_W),
    parameter int ADDR_W     = GRP_W + BANK_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_hi,
    output logic              irq_mid,
    output logic              irq_lo
);

    logic [NUM_BANKS-1:0][WORD_W-1:0]                 set_vec;
    logic [NUM_BANKS-1:0][WORD_W-1:0]                 clr_vec;
    logic [NUM_BANKS-1:0][WORD_W-1:0]                 pend;
    logic [NUM_LEVELS-1:0][NUM_BANKS-1:0]             mask_we;
    logic [NUM_LEVELS-1:0][NUM_BANKS-1:0][WORD_W-1:0] mask;
    logic [NUM_LEVELS-1:0]                            req;
    reg_grp_e                                         grp;
    logic [BANK_SEL_W-1:0]                            bsel;
    logic                                             bank_ok;

    // Split the offset into its group and bank fields.
    always_comb begin
        grp     = reg_grp_e'(reg_addr[ADDR_W-1 -: GRP_W]);
        bsel    = reg_addr[BANK_SEL_W-1:0];
        bank_ok = int'(bsel) < NUM_BANKS;
    end

    evt_code_decode #(
        .WORD_W     (WORD_W),
        .NUM_BANKS  (NUM_BANKS),
        .BANK_SEL_W (BANK_SEL_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .set_vec   (set_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
        // Route a write to pending word b as its clear vector.
        always_comb begin
            clr_vec[b] = (reg_we && grp == GRP_PEND && int'(bsel) == b) ? reg_wdata : '0;
        end

        pend_bank #(.WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_vec[b]),
            .clr_vec (clr_vec[b]),
            .pend    (pend[b])
        );
    end

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_mwe
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Enable the mask word named by group l+1 and bank b.
            always_comb begin
                mask_we[l][b] = reg_we && (int'(grp) == l + 1) && (int'(bsel) == b);
            end
        end
    end

    mask_file #(
        .WORD_W     (WORD_W),
        .NUM_BANKS  (NUM_BANKS),
        .NUM_LEVELS (NUM_LEVELS)
    ) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_data (reg_wdata),
        .mask    (mask)
    );

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        level_combine #(
            .WORD_W    (WORD_W),
            .NUM_BANKS (NUM_BANKS)
        ) u_comb (
            .pend (pend),
            .mask (mask[l]),
            .req  (req[l])
        );
    end

    // Map level 0 (set A) to the highest request, level 2 (set C) to the lowest.
    always_comb begin
        irq_hi  = req[0];
        irq_mid = req[1];
        irq_lo  = req[2];
    end

    // Select the read word; unused bank slots return zero.
    always_comb begin
        reg_rdata = '0;
        if (bank_ok) begin
            if (grp == GRP_PEND) begin
                reg_rdata = pend[bsel];
            end
            for (int l = 0; l < NUM_LEVELS; l++) begin
                if (int'(grp) == l + 1) begin
                    reg_rdata = mask[l][bsel];
                end
            end
        end
    end

    // R1: a clock edge under reset leaves all state cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && !irq_hi && !irq_mid && !irq_lo));

    // R10: a write to an unused slot changes no pending word or mask word.
    a_r10_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !bank_ok && !evt_valid) |=> ($stable(pend) && $stable(mask)));

endmodule

// File: tb/evt_irq_agg_tb.sv
// Scoreboard bench: driver tasks push expected words, a monitor checks them.
module evt_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_code = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_hi, irq_mid, irq_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] m_pend [3];
    logic [31:0] m_mask [3][3];

    always #2.5 clk = ~clk;

    evt_irq_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_hi    (irq_hi),
        .irq_mid   (irq_mid),
        .irq_lo    (irq_lo)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a[1:0] == 2'd3) return '0;
        if (a[3:2] == 2'd0) return m_pend[a[1:0]];
        return m_mask[a[3:2] - 2'd1][a[1:0]];
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] r = '0;
        for (int l = 0; l < 3; l++)
            for (int b = 0; b < 3; b++)
                if ((m_pend[b] & m_mask[l][b]) != 0) r[2 - l] = 1'b1;
        return r;
    endfunction

    // Drive one cycle of stimulus and update the model for the next edge.
    task automatic op(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic ev, input logic [6:0] c);
        @(posedge clk);
        #1;
        reg_we = we; reg_addr = a; reg_wdata = d; evt_valid = ev; evt_code = c;
        if (we && a[1:0] != 2'd3) begin
            if (a[3:2] == 2'd0) m_pend[a[1:0]] &= ~d;
            else m_mask[a[3:2] - 2'd1][a[1:0]] = d;
        end
        if (ev && c[6:5] != 2'd3) m_pend[c[6:5]][c[4:0]] = 1'b1;
    endtask

    task automatic chk_reg(input logic [3:0] a, input string tag);
        op(1'b0, a, '0, 1'b0, '0);
        exp_q.push_back({1'b0, model_read(a)});
        tag_q.push_back(tag);
    endtask

    task automatic chk_irq(input string tag);
        op(1'b0, '0, '0, 1'b0, '0);
        exp_q.push_back({1'b1, 29'd0, model_irq()});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued item per cycle, away from the clock edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [32:0] e;
            logic [31:0] act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = e[32] ? {29'd0, irq_hi, irq_mid, irq_lo} : reg_rdata;
            n_checks++;
            if (act !== e[31:0]) begin
                n_fails++;
                $display("FAIL %s: actual %08h expected %08h", t, act, e[31:0]);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int b = 0; b < 3; b++) begin
            m_pend[b] = '0;
            for (int l = 0; l < 3; l++) m_mask[l][b] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: everything cleared after reset
        for (int a = 0; a < 16; a++) chk_reg(4'(a), "R1 reset value");
        chk_irq("R1 requests low");

        // R9: mask words load and read back
        for (int a = 4; a < 16; a++)
            if (a % 4 != 3) op(1'b1, 4'(a), 32'hA5000000 | 32'(a), 1'b0, '0);
        for (int a = 4; a < 16; a++) chk_reg(4'(a), "R9 mask readback");
        for (int a = 4; a < 16; a++)
            if (a % 4 != 3) op(1'b1, 4'(a), '0, 1'b0, '0);

        // R2: events in each bank
        op(1'b0, '0, '0, 1'b1, 7'h00);
        op(1'b0, '0, '0, 1'b1, 7'h25);
        op(1'b0, '0, '0, 1'b1, 7'h5F);
        for (int a = 0; a < 3; a++) chk_reg(4'(a), "R2 pending set");
        chk_irq("R6 masks zero, no request");

        // R3: reserved bank codes ignored
        op(1'b0, '0, '0, 1'b1, 7'h63);
        op(1'b0, '0, '0, 1'b1, 7'h7F);
        for (int a = 0; a < 3; a++) chk_reg(4'(a), "R3 reserved code ignored");

        // R5: repeated reads return the same value
        chk_reg(4'd1, "R5 read once");
        chk_reg(4'd1, "R5 read again");

        // R6: each mask set drives its own line
        op(1'b1, 4'd5, 32'h0000_0020, 1'b0, '0);
        chk_irq("R6 mask A to irq_hi");
        op(1'b1, 4'd10, 32'h8000_0000, 1'b0, '0);
        chk_irq("R6 mask B to irq_mid");
        op(1'b1, 4'd12, 32'h0000_0001, 1'b0, '0);
        chk_irq("R6 mask C to irq_lo");

        // R4 and R7: clear pending word 1 bit 5, irq_hi drops next cycle
        op(1'b1, 4'd1, 32'h0000_0020, 1'b0, '0);
        chk_irq("R7 irq_hi drops after clear");
        chk_reg(4'd1, "R4 clear by writing one");

        // R4: zero bits of a write leave pending bits alone
        op(1'b1, 4'd2, 32'h7FFF_FFFF, 1'b0, '0);
        chk_reg(4'd2, "R4 zero bits kept");

        // R7: mask change drops irq_lo next cycle
        op(1'b1, 4'd12, '0, 1'b0, '0);
        chk_irq("R7 irq_lo drops after mask clear");

        // R8: event and clear on the same bit in one cycle
        op(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b1, 7'h05);
        chk_reg(4'd0, "R8 event beats clear");

        // R10: unused offsets read zero and writes change nothing
        op(1'b1, 4'd3, 32'hFFFF_FFFF, 1'b0, '0);
        op(1'b1, 4'd7, 32'hFFFF_FFFF, 1'b0, '0);
        op(1'b1, 4'd11, 32'hFFFF_FFFF, 1'b0, '0);
        op(1'b1, 4'd15, 32'hFFFF_FFFF, 1'b0, '0);
        for (int a = 0; a < 16; a++) chk_reg(4'(a), "R10 unused slots inert");

        // R2: sweep every bit position of bank 2
        op(1'b1, 4'd2, 32'hFFFF_FFFF, 1'b0, '0);
        for (int i = 0; i < 32; i++) begin
            op(1'b0, '0, '0, 1'b1, {2'b10, 5'(i)});
            chk_reg(4'd2, "R2 bit sweep");
        end
        chk_irq("R6 bank 2 full against mask B");

        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule